// File: doc/BRIEF.md
# Serial Command Frame Port with Chained Output

This block is the slave side of a three-wire synchronous serial link that carries 24-bit commands into a multi-channel converter control path. The system clock oversamples the serial clock, the active-low frame strobe and the data input. Each of them passes through a two-flop synchronizer, and all edges are found in the system clock domain. While the strobe is low, each falling serial clock edge shifts one data bit into a 24-bit shift register, most significant bit first. When the strobe rises, the block checks the bit count. It then either hands the word to the downstream register logic with a one-cycle valid pulse, or it drops the word and pulses a framing-error flag.

The same shift register drives the serial output, which has two uses. In chained operation, a frame longer than 24 clocks pushes the bits received earlier in the frame out to the next device 24 clocks later. This lets one long frame load several devices in series. For readback, the register logic raises a load request with the selected register's contents before the next frame starts. The shift register is preloaded at the strobe's falling edge, and that frame's clocks shift the data out. The output only changes after rising serial clock edges, so a receiver can sample it on falling edges. A pad-enable output is active only while the strobe is low.

Top module: `serial_frame_port`

## Requirements
- R1: A frame shifts its bits in most significant bit first. On acceptance, `word_o` holds the last 24 bits received, with the first of those in bit 23. `word_vld_o` pulses high for exactly one system clock.
- R2: Serial clock edges while the frame strobe is high change neither the output word, the flags, nor the shift register contents later seen on `sdo_o`.
- R3: The word is delivered only after the strobe rises. No `word_vld_o` appears between the 24th falling clock edge and the strobe's rising edge.
- R4: With `chain_en_i` low, a frame whose falling-edge count is not exactly 24 raises a one-cycle `frame_err_o` and no `word_vld_o`, and it leaves `word_o` unchanged. `word_vld_o` and `frame_err_o` are never high together.
- R5: With `chain_en_i` high, any nonzero multiple of 24 falling edges is accepted, and the word is the last 24 bits received. Any other count is a framing error.
- R6: During frame clock k, counting from 0, with k at least 24, `sdo_o` carries the bit that was shifted in at clock k-24 of the same frame.
- R7: If `rd_vld_i` is high when the strobe falls, `rd_data_i` is loaded into the shift register. Bit 23 appears on `sdo_o` from the strobe's falling edge, and the following bits appear in descending order after each rising clock edge.
- R8: Without a readback load, the first 24 output bits of a frame are the 24 bits the shift register held at the strobe's fall. These are the last 24 bits received by earlier frames, with zeros after reset filling any gap.
- R9: `sdo_o` changes only at the strobe's falling edge or after a rising serial clock edge. It holds its value across falling edges.
- R10: `sdo_oe_o` is high while the synchronized strobe is low and low otherwise. `sdo_o` does not change while `sdo_oe_o` is low.
- R11: After reset, `word_o` is zero, both pulse outputs are low and `sdo_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idles high |
| frame_n_i | input | 1 | Active-low frame strobe |
| sdin_i | input | 1 | Serial data input |
| chain_en_i | input | 1 | Accept multiples of 24 clocks per frame |
| rd_vld_i | input | 1 | Preload readback data at the next frame start |
| rd_data_i | input | 24 | Readback data to shift out |
| word_o | output | 24 | Last accepted command word |
| word_vld_o | output | 1 | One-cycle pulse on an accepted frame |
| frame_err_o | output | 1 | One-cycle pulse on a rejected frame |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Output driver enable |

## Verification
The bench sends frames of exactly 24 clocks with distinct bit patterns. Back-to-back frames show that the first 24 output bits of each frame repeat the previous word, which separates a correct bit order and shift depth from a reversed or off-by-one shifter. Frames of 23 and 25 clocks, and frames of 48 clocks in both modes, are used to test the acceptance rule. A 30-clock chained frame shows that acceptance is based on multiples of 24 and not on a simple minimum. The bench also sends a 48-clock chained frame and a readback-preloaded frame, and checks every output bit before and after each falling edge. Serial clock toggles with the strobe high are placed before a normal frame so that any stray shift shows up on the output.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
    localparam int unsigned SFI_FRAME_BITS = 24;

    // saturating count of whole words seen in one strobe-low period
    typedef logic [1:0] word_cnt_t;

    function automatic logic frame_accept(input logic aligned,
                                          input word_cnt_t words,
                                          input logic chain);
        return aligned && (words != 2'd0) && (chain || (words == 2'd1));
    endfunction
endpackage

// File: rtl/sfi_sync.sv
module sfi_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta = d_i;
        s_d.stab = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{meta: RST_VAL, stab: RST_VAL};
        else        s_q <= s_d;
    end

    assign q_o = s_q.stab;
endmodule

// File: rtl/sfi_edge.sv
module sfi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s_i,
    input  logic frame_s_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic frm_start_o,
    output logic frm_end_o
);
    typedef struct packed {
        logic sclk;
        logic frame;
    } prev_t;

    prev_t p_d, p_q;

    always_comb begin
        p_d.sclk  = sclk_s_i;
        p_d.frame = frame_s_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{sclk: 1'b1, frame: 1'b1};
        else        p_q <= p_d;
    end

    assign sclk_rise_o = !p_q.sclk && sclk_s_i;
    assign sclk_fall_o = p_q.sclk && !sclk_s_i;
    assign frm_start_o = p_q.frame && !frame_s_i;
    assign frm_end_o   = !p_q.frame && frame_s_i;
endmodule

// File: rtl/sfi_shifter.sv
module sfi_shifter #(
    parameter int unsigned FRAME_BITS = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  active_i,
    input  logic                  sclk_rise_i,
    input  logic                  sclk_fall_i,
    input  logic                  frm_start_i,
    input  logic                  sdin_s_i,
    input  logic                  rd_vld_i,
    input  logic [FRAME_BITS-1:0] rd_data_i,
    output logic [FRAME_BITS-1:0] shreg_o,
    output logic                  sdo_o
);
    localparam int unsigned MSB = FRAME_BITS - 1;

    typedef struct packed {
        logic [FRAME_BITS-1:0] shreg;
        logic                  sdo;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (frm_start_i) begin
            s_d.shreg = rd_vld_i ? rd_data_i : s_q.shreg;
            s_d.sdo   = s_d.shreg[MSB];
        end else if (active_i) begin
            if (sclk_fall_i) s_d.shreg = {s_q.shreg[MSB-1:0], sdin_s_i};
            if (sclk_rise_i) s_d.sdo   = s_q.shreg[MSB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign shreg_o = s_q.shreg;
    assign sdo_o   = s_q.sdo;
endmodule

// File: rtl/sfi_frame_ctl.sv
module sfi_frame_ctl
    import sfi_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  active_i,
    input  logic                  sclk_fall_i,
    input  logic                  frm_start_i,
    input  logic                  frm_end_i,
    input  logic                  chain_i,
    input  logic [FRAME_BITS-1:0] shreg_i,
    output logic [FRAME_BITS-1:0] word_o,
    output logic                  word_vld_o,
    output logic                  frame_err_o
);
    localparam int unsigned CW   = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

    typedef struct packed {
        logic [CW-1:0]         bit_idx;
        word_cnt_t             words;
        logic [FRAME_BITS-1:0] word;
        logic                  vld;
        logic                  err;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.vld = 1'b0;
        c_d.err = 1'b0;
        if (frm_start_i) begin
            c_d.bit_idx = '0;
            c_d.words   = '0;
        end else if (frm_end_i) begin
            if (frame_accept(c_q.bit_idx == '0, c_q.words, chain_i)) begin
                c_d.vld  = 1'b1;
                c_d.word = shreg_i;
            end else begin
                c_d.err  = 1'b1;
            end
            c_d.bit_idx = '0;
            c_d.words   = '0;
        end else if (active_i && sclk_fall_i) begin
            if (c_q.bit_idx == LAST) begin
                c_d.bit_idx = '0;
                if (c_q.words != 2'd3) c_d.words = c_q.words + 2'd1;
            end else begin
                c_d.bit_idx = c_q.bit_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign word_o      = c_q.word;
    assign word_vld_o  = c_q.vld;
    assign frame_err_o = c_q.err;
endmodule

// File: rtl/serial_frame_port.sv
module serial_frame_port
    import sfi_pkg::*;
#(
    parameter int unsigned FRAME_BITS = SFI_FRAME_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_i,
    input  logic                  frame_n_i,
    input  logic                  sdin_i,
    input  logic                  chain_en_i,
    input  logic                  rd_vld_i,
    input  logic [FRAME_BITS-1:0] rd_data_i,
    output logic [FRAME_BITS-1:0] word_o,
    output logic                  word_vld_o,
    output logic                  frame_err_o,
    output logic                  sdo_o,
    output logic                  sdo_oe_o
);
    logic [2:0]            pins_s;
    logic                  sclk_rise, sclk_fall, frm_start, frm_end, active;
    logic [FRAME_BITS-1:0] shreg;

    // order {data, strobe, clock}; strobe and clock idle high
    sfi_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sdin_i, frame_n_i, sclk_i}),
        .q_o   (pins_s)
    );

    sfi_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s_i    (pins_s[0]),
        .frame_s_i   (pins_s[1]),
        .sclk_rise_o (sclk_rise),
        .sclk_fall_o (sclk_fall),
        .frm_start_o (frm_start),
        .frm_end_o   (frm_end)
    );

    assign active = !pins_s[1];

    sfi_shifter #(.FRAME_BITS(FRAME_BITS)) u_shf (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (active),
        .sclk_rise_i (sclk_rise),
        .sclk_fall_i (sclk_fall),
        .frm_start_i (frm_start),
        .sdin_s_i    (pins_s[2]),
        .rd_vld_i    (rd_vld_i),
        .rd_data_i   (rd_data_i),
        .shreg_o     (shreg),
        .sdo_o       (sdo_o)
    );

    sfi_frame_ctl #(.FRAME_BITS(FRAME_BITS)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (active),
        .sclk_fall_i (sclk_fall),
        .frm_start_i (frm_start),
        .frm_end_i   (frm_end),
        .chain_i     (chain_en_i),
        .shreg_i     (shreg),
        .word_o      (word_o),
        .word_vld_o  (word_vld_o),
        .frame_err_o (frame_err_o)
    );

    assign sdo_oe_o = active;
endmodule

// File: rtl/sfi_checker.sv
module sfi_checker #(
    parameter int unsigned FRAME_BITS = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [FRAME_BITS-1:0] word_o,
    input logic                  word_vld_o,
    input logic                  frame_err_o,
    input logic                  sdo_o,
    input logic                  sdo_oe_o
);
    assert_vld_err_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_vld_o && frame_err_o));

    assert_vld_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |=> !word_vld_o);

    assert_vld_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> !$past(sdo_oe_o));

    assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld_o |-> $stable(word_o));

    assert_sdo_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe_o |-> $stable(sdo_o));
endmodule

bind serial_frame_port sfi_checker #(.FRAME_BITS(FRAME_BITS)) u_sfi_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_o      (word_o),
    .word_vld_o  (word_vld_o),
    .frame_err_o (frame_err_o),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o)
);

// File: tb/tb_serial_frame_port.sv
module tb_serial_frame_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        frame_n = 1'b1;
    logic        sdin = 1'b0;
    logic        chain_en = 1'b0;
    logic        rd_vld = 1'b0;
    logic [23:0] rd_data = '0;
    logic [23:0] word_o;
    logic        word_vld_o, frame_err_o, sdo_o, sdo_oe_o;

    int compared = 0;
    int mismatched = 0;
    int vld_seen = 0;
    int err_seen = 0;
    logic [23:0] last_word = '0;
    logic [23:0] hist = '0;   // behavioural model of the bits held for output
    logic [23:0] good_word = '0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_frame_port dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .frame_n_i(frame_n),
        .sdin_i(sdin), .chain_en_i(chain_en), .rd_vld_i(rd_vld),
        .rd_data_i(rd_data), .word_o(word_o), .word_vld_o(word_vld_o),
        .frame_err_o(frame_err_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
    );

    always @(negedge clk) begin
        if (word_vld_o) begin vld_seen++; last_word = word_o; end
        if (frame_err_o) err_seen++;
    end

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [47:0] data, input int n, input logic rb,
                        input logic [23:0] rbd);
        logic  exp_bit;
        string tag;
        vld_seen = 0;
        err_seen = 0;
        rd_vld  = rb;
        rd_data = rbd;
        @(negedge clk) frame_n = 1'b0;
        if (rb) hist = rbd;
        repeat (HALF + 2) @(negedge clk);
        chk("R10 oe in frame", 24'(sdo_oe_o), 24'd1);
        for (int k = 0; k < n; k++) begin
            tag  = (k >= 24) ? "R6 chained out" : (rb ? "R7 readback" : "R8 held bits");
            sdin = data[n-1-k];
            repeat (HALF) @(negedge clk);
            exp_bit = hist[23];
            chk(tag, 24'(sdo_o), 24'(exp_bit));
            sclk = 1'b0;
            hist = {hist[22:0], data[n-1-k]};
            repeat (HALF) @(negedge clk);
            chk("R9 hold across fall", 24'(sdo_o), 24'(exp_bit));
            sclk = 1'b1;
        end
        repeat (HALF) @(negedge clk);
        chk("R3 no early word", 24'(vld_seen), 24'd0);
        frame_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R10 oe idle", 24'(sdo_oe_o), 24'd0);
        rd_vld = 1'b0;
    endtask

    task automatic expect_ok(input string req, input logic [23:0] w);
        chk(req, 24'(vld_seen), 24'd1);
        chk(req, 24'(err_seen), 24'd0);
        chk(req, last_word, w);
        chk(req, word_o, w);
        good_word = w;
    endtask

    task automatic expect_err(input string req);
        chk(req, 24'(err_seen), 24'd1);
        chk(req, 24'(vld_seen), 24'd0);
        chk(req, word_o, good_word);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk("R11 word", word_o, 24'd0);
        chk("R11 vld", 24'(word_vld_o), 24'd0);
        chk("R11 err", 24'(frame_err_o), 24'd0);
        chk("R11 oe", 24'(sdo_oe_o), 24'd0);

        // R1: plain frames, output repeats earlier word (R8)
        send(48'hA5C33C, 24, 1'b0, '0);
        expect_ok("R1 first word", 24'hA5C33C);
        send(48'h123456, 24, 1'b0, '0);
        expect_ok("R1 second word", 24'h123456);

        // R2: clock toggles with strobe high are ignored
        vld_seen = 0;
        err_seen = 0;
        sdin = 1'b1;
        for (int i = 0; i < 5; i++) begin
            repeat (HALF) @(negedge clk) sclk = 1'b0;
            repeat (HALF) @(negedge clk) sclk = 1'b1;
        end
        repeat (8) @(negedge clk);
        chk("R2 no vld", 24'(vld_seen), 24'd0);
        chk("R2 no err", 24'(err_seen), 24'd0);
        chk("R2 word kept", word_o, 24'h123456);
        send(48'hF0F00F, 24, 1'b0, '0);
        expect_ok("R2 next frame", 24'hF0F00F);

        // R4: wrong lengths in single mode
        send(48'h7FFFFE, 23, 1'b0, '0);
        expect_err("R4 short frame");
        send(48'h1ABCDEF, 25, 1'b0, '0);
        expect_err("R4 long frame");
        send(48'h111111_222222, 48, 1'b0, '0);
        expect_err("R4 double frame single mode");

        // R5/R6: chained mode
        chain_en = 1'b1;
        send(48'hC0FFEE_5A5A5A, 48, 1'b0, '0);
        expect_ok("R5 chained 48", 24'h5A5A5A);
        send(48'h0F1E2D, 24, 1'b0, '0);
        expect_ok("R5 chained 24", 24'h0F1E2D);
        send(48'h3C_A1B2C3D4, 30, 1'b0, '0);
        expect_err("R5 chained 30");
        chain_en = 1'b0;

        // R7: readback preload
        send(48'h000000, 24, 1'b1, 24'hFEDCBA);
        expect_ok("R7 nop frame", 24'h000000);
        send(48'h9C9C9C, 24, 1'b1, 24'h5AA5C3);
        expect_ok("R7 second readback", 24'h9C9C9C);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule